// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block stores the per-line state of a configurable set of interrupt lines and makes it visible through a small word-addressed register bus. Each line carries an enable bit, a pending latch, an active bit, a priority value, a trigger type (edge or level) and an input line level. Software sets and clears the single-bit states through paired write-one registers. It programs priorities one byte per line and trigger types two bits per line. A separate window lets the stored line levels be saved and restored. Every access completes in one cycle, and a read response is registered.

The low-numbered lines are private. Their trigger type is fixed at level, and the first sixteen of them are software-generated lines, which the level window skips. Priority values are kept only to the supported precision. For every line, the bank drives its effective pending state and its enable state out to a downstream selector, which performs the arbitration.

Top module: `irqd_bank`

## Requirements
- R1: After reset every line is disabled, not pending, not active, level triggered, with priority 0 and line level 0. `bus_rdata` and `bus_rvalid` are 0, and both line vectors are all zero.
- R2: Enable bits are written at word addresses 0x00+w (set) and 0x08+w (clear). Word w, bit b covers line 32w+b. A 1 sets or clears that line, and a 0 leaves it unchanged. A read at either address returns the current enable bits.
- R3: Pending latches are written at 0x10+w (set) and 0x18+w (clear) with the same bit layout. A read at either address, and `irq_pending_o`, report a line as pending when its latch is set or when it is level triggered with its line level high.
- R4: Active bits are written at 0x20+w (set) and 0x28+w (clear) with the same bit layout. A read at either address returns the active bits.
- R5: Priority word 0x40+w holds line 4w+k in byte lane k (bits 8k+7..8k). Only the top PRIO_BITS bits (5 by default) of each byte are stored, and the lower bits read back as zero.
- R6: Configuration word 0x80+w covers line 16w+f. Bit 2f+1 set selects edge triggering and clear selects level triggering. A read returns 2'b10 in the field for an edge line and 2'b00 for a level line. Writes to lines below NUM_PRIV (32) are ignored.
- R7: Level window word 0x90+w covers line 32w+b at bit b. Lines below NUM_SGI (16) and at or above the line count are skipped. A read returns 1 only for a level-triggered line whose stored level is high. A write stores the level whatever the trigger type.
- R8: A write changes only the state held in byte lanes whose `bus_be` bit is set.
- R9: Bit positions that map to line numbers at or above the implemented count read as 0, and writes to them have no effect.
- R10: A read access (`bus_sel` high, `bus_we` low) presents its data on `bus_rdata` with `bus_rvalid` high in the cycle that follows. A write access produces no `bus_rvalid`.
- R11: `irq_enable_o[i]` equals the enable bit of line i, and `irq_pending_o[i]` equals its pending view from R3, each one cycle after the write that changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Word address |
| bus_be | input | 4 | Byte strobes for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid |
| irq_pending_o | output | NUM_PRIV+NUM_SHARED | Effective pending state per line |
| irq_enable_o | output | NUM_PRIV+NUM_SHARED | Enable state per line |

## Verification
The bit registers are exercised with sparse, dense and partial-strobe write patterns. Reading back each one through the opposite address of its set/clear pair distinguishes a shared read view from two separate registers. Priority bytes with every low bit set show that the precision is truncated and that each byte lands in its own lane. A configuration word of all ones separates locked private lines from shared lines, and an odd-bit pattern shows that only bit 2f+1 matters. Line levels are written to edge lines and then to level lines, and the line types are changed afterwards. This tells apart the stored level, its level-window view and its contribution to the pending view.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;
  localparam int WORD_W = 6;

  typedef enum logic [3:0] {
    RG_NONE,
    RG_ENA_SET,
    RG_ENA_CLR,
    RG_PND_SET,
    RG_PND_CLR,
    RG_ACT_SET,
    RG_ACT_CLR,
    RG_PRIO,
    RG_CFG,
    RG_LVL
  } region_e;
endpackage

// File: rtl/irqd_decode.sv
module irqd_decode
  import irqd_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [WORD_W-1:0] word
);
  always_comb begin
    region = RG_NONE;
    word   = '0;
    if (addr[7:6] == 2'b00) begin
      word = {3'b000, addr[2:0]};
      case (addr[5:3])
        3'd0:    region = RG_ENA_SET;
        3'd1:    region = RG_ENA_CLR;
        3'd2:    region = RG_PND_SET;
        3'd3:    region = RG_PND_CLR;
        3'd4:    region = RG_ACT_SET;
        3'd5:    region = RG_ACT_CLR;
        default: region = RG_NONE;
      endcase
    end else if (addr[7:6] == 2'b01) begin
      region = RG_PRIO;
      word   = addr[5:0];
    end else if (addr[7:4] == 4'h8) begin
      region = RG_CFG;
      word   = {2'b00, addr[3:0]};
    end else if (addr[7:3] == 5'b10010) begin
      region = RG_LVL;
      word   = {3'b000, addr[2:0]};
    end
  end
endmodule

// File: rtl/irqd_line.sv
module irqd_line #(
  parameter int PRIO_BITS  = 5,
  parameter bit CFG_LOCKED = 1'b0,
  parameter bit LVL_LOCKED = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 set_ena,
  input  logic                 clr_ena,
  input  logic                 set_pnd,
  input  logic                 clr_pnd,
  input  logic                 set_act,
  input  logic                 clr_act,
  input  logic                 prio_we,
  input  logic [PRIO_BITS-1:0] prio_in,
  input  logic                 cfg_we,
  input  logic                 cfg_edge_in,
  input  logic                 lvl_we,
  input  logic                 lvl_in,
  output logic                 ena,
  output logic                 act,
  output logic                 edge_trig,
  output logic                 lvl,
  output logic                 pend_eff,
  output logic [PRIO_BITS-1:0] prio
);
  logic                 ena_q, ena_d;
  logic                 pnd_q, pnd_d;
  logic                 act_q, act_d;
  logic                 edge_q, edge_d;
  logic                 lvl_q, lvl_d;
  logic [PRIO_BITS-1:0] prio_q, prio_d;

  always_comb begin
    ena_d  = ena_q;
    pnd_d  = pnd_q;
    act_d  = act_q;
    edge_d = edge_q;
    lvl_d  = lvl_q;
    prio_d = prio_q;
    if (set_ena)      ena_d = 1'b1;
    else if (clr_ena) ena_d = 1'b0;
    if (set_pnd)      pnd_d = 1'b1;
    else if (clr_pnd) pnd_d = 1'b0;
    if (set_act)      act_d = 1'b1;
    else if (clr_act) act_d = 1'b0;
    if (prio_we)      prio_d = prio_in;
    if (cfg_we && !CFG_LOCKED) edge_d = cfg_edge_in;
    if (lvl_we && !LVL_LOCKED) lvl_d  = lvl_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ena_q  <= 1'b0;
      pnd_q  <= 1'b0;
      act_q  <= 1'b0;
      edge_q <= 1'b0;
      lvl_q  <= 1'b0;
      prio_q <= '0;
    end else begin
      ena_q  <= ena_d;
      pnd_q  <= pnd_d;
      act_q  <= act_d;
      edge_q <= edge_d;
      lvl_q  <= lvl_d;
      prio_q <= prio_d;
    end
  end

  assign ena       = ena_q;
  assign act       = act_q;
  assign edge_trig = edge_q;
  assign lvl       = lvl_q;
  assign prio      = prio_q;
  assign pend_eff  = pnd_q | (~edge_q & lvl_q);

  assert_set_ena_R2: assert property (@(posedge clk) disable iff (!rst_n)
    set_ena |=> ena_q);
  assert_clr_ena_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ena && !set_ena) |=> !ena_q);
  assert_set_act_R4: assert property (@(posedge clk) disable iff (!rst_n)
    set_act |=> act_q);
  assert_clr_act_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_act && !set_act) |=> !act_q);

  generate
    if (CFG_LOCKED) begin : g_cfg_lock
      assert_cfg_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> !edge_q);
    end
    if (LVL_LOCKED) begin : g_lvl_lock
      assert_lvl_skipped_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_we |=> !lvl_q);
    end
  endgenerate
endmodule

// File: rtl/irqd_rdmux.sv
module irqd_rdmux
  import irqd_pkg::*;
#(
  parameter int NUM_IRQ   = 96,
  parameter int NUM_SGI   = 16,
  parameter int PRIO_BITS = 5
) (
  input  region_e                        region,
  input  logic [WORD_W-1:0]              word,
  input  logic [NUM_IRQ-1:0]             ena_v,
  input  logic [NUM_IRQ-1:0]             pend_v,
  input  logic [NUM_IRQ-1:0]             act_v,
  input  logic [NUM_IRQ-1:0]             edge_v,
  input  logic [NUM_IRQ-1:0]             lvl_v,
  input  logic [NUM_IRQ*PRIO_BITS-1:0]   prio_flat,
  output logic [DATA_W-1:0]              rd_word
);
  localparam int PAD = 8 - PRIO_BITS;

  always_comb begin
    rd_word = '0;
    case (region)
      RG_ENA_SET, RG_ENA_CLR: begin
        for (int b = 0; b < 32; b++) begin
          if (int'(word) * 32 + b < NUM_IRQ) rd_word[b] = ena_v[int'(word) * 32 + b];
        end
      end
      RG_PND_SET, RG_PND_CLR: begin
        for (int b = 0; b < 32; b++) begin
          if (int'(word) * 32 + b < NUM_IRQ) rd_word[b] = pend_v[int'(word) * 32 + b];
        end
      end
      RG_ACT_SET, RG_ACT_CLR: begin
        for (int b = 0; b < 32; b++) begin
          if (int'(word) * 32 + b < NUM_IRQ) rd_word[b] = act_v[int'(word) * 32 + b];
        end
      end
      RG_PRIO: begin
        for (int l = 0; l < 4; l++) begin
          if (int'(word) * 4 + l < NUM_IRQ)
            rd_word[8*l +: 8] = {prio_flat[(int'(word) * 4 + l) * PRIO_BITS +: PRIO_BITS],
                                 {PAD{1'b0}}};
        end
      end
      RG_CFG: begin
        for (int f = 0; f < 16; f++) begin
          if (int'(word) * 16 + f < NUM_IRQ) rd_word[2*f+1] = edge_v[int'(word) * 16 + f];
        end
      end
      RG_LVL: begin
        for (int b = 0; b < 32; b++) begin
          if ((int'(word) * 32 + b < NUM_IRQ) && (int'(word) * 32 + b >= NUM_SGI))
            rd_word[b] = lvl_v[int'(word) * 32 + b] & ~edge_v[int'(word) * 32 + b];
        end
      end
      default: rd_word = '0;
    endcase
  end
endmodule

// File: rtl/irqd_bank.sv
module irqd_bank
  import irqd_pkg::*;
#(
  parameter int NUM_PRIV   = 32,
  parameter int NUM_SGI    = 16,
  parameter int NUM_SHARED = 64,
  parameter int PRIO_BITS  = 5
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bus_sel,
  input  logic                           bus_we,
  input  logic [7:0]                     bus_addr,
  input  logic [3:0]                     bus_be,
  input  logic [31:0]                    bus_wdata,
  output logic [31:0]                    bus_rdata,
  output logic                           bus_rvalid,
  output logic [NUM_PRIV+NUM_SHARED-1:0] irq_pending_o,
  output logic [NUM_PRIV+NUM_SHARED-1:0] irq_enable_o
);
  localparam int NUM_IRQ = NUM_PRIV + NUM_SHARED;
  localparam int PAD     = 8 - PRIO_BITS;

  region_e             region;
  logic [WORD_W-1:0]   word;
  logic                wr_acc, rd_acc;
  logic [NUM_IRQ-1:0]  ena_v, pend_v, act_v, edge_v, lvl_v;
  logic [NUM_IRQ*PRIO_BITS-1:0] prio_flat;
  logic [DATA_W-1:0]   rd_word;
  logic [DATA_W-1:0]   rdata_q, rdata_d;
  logic                rvalid_q, rvalid_d;

  assign wr_acc = bus_sel & bus_we;
  assign rd_acc = bus_sel & ~bus_we;

  irqd_decode u_decode (
    .addr   (bus_addr),
    .region (region),
    .word   (word)
  );

  generate
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
      localparam int BW = i / 32;
      localparam int BB = i % 32;
      localparam int PW = i / 4;
      localparam int PL = i % 4;
      localparam int CW = i / 16;
      localparam int CB = 2 * (i % 16) + 1;

      logic bit_hit, prio_hit, cfg_hit;
      assign bit_hit  = (word == WORD_W'(BW)) & bus_be[BB/8] & bus_wdata[BB] & wr_acc;
      assign prio_hit = (word == WORD_W'(PW)) & bus_be[PL] & wr_acc & (region == RG_PRIO);
      assign cfg_hit  = (word == WORD_W'(CW)) & bus_be[CB/8] & wr_acc & (region == RG_CFG);

      logic lvl_hit;
      assign lvl_hit = (word == WORD_W'(BW)) & bus_be[BB/8] & wr_acc & (region == RG_LVL);

      irqd_line #(
        .PRIO_BITS  (PRIO_BITS),
        .CFG_LOCKED (i < NUM_PRIV),
        .LVL_LOCKED (i < NUM_SGI)
      ) u_line (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_ena     (bit_hit & (region == RG_ENA_SET)),
        .clr_ena     (bit_hit & (region == RG_ENA_CLR)),
        .set_pnd     (bit_hit & (region == RG_PND_SET)),
        .clr_pnd     (bit_hit & (region == RG_PND_CLR)),
        .set_act     (bit_hit & (region == RG_ACT_SET)),
        .clr_act     (bit_hit & (region == RG_ACT_CLR)),
        .prio_we     (prio_hit),
        .prio_in     (bus_wdata[8*PL+PAD +: PRIO_BITS]),
        .cfg_we      (cfg_hit),
        .cfg_edge_in (bus_wdata[CB]),
        .lvl_we      (lvl_hit),
        .lvl_in      (bus_wdata[BB]),
        .ena         (ena_v[i]),
        .act         (act_v[i]),
        .edge_trig   (edge_v[i]),
        .lvl         (lvl_v[i]),
        .pend_eff    (pend_v[i]),
        .prio        (prio_flat[i*PRIO_BITS +: PRIO_BITS])
      );
    end
  endgenerate

  irqd_rdmux #(
    .NUM_IRQ   (NUM_IRQ),
    .NUM_SGI   (NUM_SGI),
    .PRIO_BITS (PRIO_BITS)
  ) u_rdmux (
    .region    (region),
    .word      (word),
    .ena_v     (ena_v),
    .pend_v    (pend_v),
    .act_v     (act_v),
    .edge_v    (edge_v),
    .lvl_v     (lvl_v),
    .prio_flat (prio_flat),
    .rd_word   (rd_word)
  );

  always_comb begin
    rvalid_d = rd_acc;
    rdata_d  = rdata_q;
    if (rd_acc) rdata_d = rd_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rdata_q  <= rdata_d;
      rvalid_q <= rvalid_d;
    end
  end

  assign bus_rdata     = rdata_q;
  assign bus_rvalid    = rvalid_q;
  assign irq_pending_o = pend_v;
  assign irq_enable_o  = ena_v;

  assert_rvalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> bus_rvalid);
  assert_no_rvalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> !bus_rvalid);
  assert_prio_low_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && region == RG_PRIO) |=>
      ((bus_rdata & {4{{PRIO_BITS{1'b0}}, {PAD{1'b1}}}}) == '0));
  assert_level_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((lvl_v & ~edge_v & ~irq_pending_o) == '0));
endmodule

// File: tb/tb_irqd_bank.sv
module tb_irqd_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NIRQ = 96;
  localparam int NVEC = 34;

  // entry: {write, addr[8], be[4], wdata[32], expected read[32]}
  localparam logic [76:0] VEC [NVEC] = '{
    {1'b1, 8'h00, 4'hF, 32'h0000_00F1, 32'h0},           // R2 set enable
    {1'b0, 8'h08, 4'hF, 32'h0,         32'h0000_00F1},   // R2 read via clear address
    {1'b1, 8'h08, 4'hF, 32'h0000_0011, 32'h0},           // R2 clear enable
    {1'b0, 8'h00, 4'hF, 32'h0,         32'h0000_00E0},   // R2
    {1'b1, 8'h01, 4'h1, 32'hFFFF_FFFF, 32'h0},           // R8 one lane only
    {1'b0, 8'h01, 4'hF, 32'h0,         32'h0000_00FF},   // R8
    {1'b1, 8'h03, 4'hF, 32'hFFFF_FFFF, 32'h0},           // R9 lines 96+
    {1'b0, 8'h03, 4'hF, 32'h0,         32'h0},           // R9
    {1'b1, 8'h48, 4'hF, 32'hFFA5_3C17, 32'h0},           // R5 priority lines 32..35
    {1'b0, 8'h48, 4'hF, 32'h0,         32'hF8A0_3810},   // R5 truncated
    {1'b1, 8'h80, 4'hF, 32'hFFFF_FFFF, 32'h0},           // R6 private cfg
    {1'b0, 8'h80, 4'hF, 32'h0,         32'h0},           // R6 stays level
    {1'b1, 8'h82, 4'hF, 32'h0000_000E, 32'h0},           // R6 odd bits only
    {1'b0, 8'h82, 4'hF, 32'h0,         32'h0000_000A},   // R6
    {1'b1, 8'h22, 4'hF, 32'h8000_0001, 32'h0},           // R4 set active
    {1'b0, 8'h2A, 4'hF, 32'h0,         32'h8000_0001},   // R4
    {1'b1, 8'h2A, 4'hF, 32'h0000_0001, 32'h0},           // R4 clear active
    {1'b0, 8'h22, 4'hF, 32'h0,         32'h8000_0000},   // R4
    {1'b1, 8'h11, 4'hF, 32'h0000_0100, 32'h0},           // R3 set pending 40
    {1'b0, 8'h19, 4'hF, 32'h0,         32'h0000_0100},   // R3
    {1'b1, 8'h91, 4'hF, 32'h0000_0007, 32'h0},           // R7 levels 32..34
    {1'b0, 8'h91, 4'hF, 32'h0,         32'h0000_0004},   // R7 only level lines
    {1'b0, 8'h11, 4'hF, 32'h0,         32'h0000_0104},   // R3 latch or level
    {1'b1, 8'h90, 4'hF, 32'hFFFF_FFFF, 32'h0},           // R7 sgi skipped
    {1'b0, 8'h90, 4'hF, 32'h0,         32'hFFFF_0000},   // R7
    {1'b0, 8'h10, 4'hF, 32'h0,         32'hFFFF_0000},   // R3 level pending
    {1'b1, 8'h19, 4'hF, 32'h0000_0104, 32'h0},           // R3 clear latches
    {1'b0, 8'h11, 4'hF, 32'h0,         32'h0000_0004},   // R3 level persists
    {1'b1, 8'h93, 4'hF, 32'hFFFF_FFFF, 32'h0},           // R9 window beyond count
    {1'b0, 8'h93, 4'hF, 32'h0,         32'h0},           // R9
    {1'b1, 8'h82, 4'hF, 32'h0000_0008, 32'h0},           // R7 line 32 to level
    {1'b0, 8'h91, 4'hF, 32'h0,         32'h0000_0005},   // R7 stored level kept
    {1'b1, 8'h48, 4'h2, 32'h0000_0000, 32'h0},           // R8 priority lane 1
    {1'b0, 8'h48, 4'hF, 32'h0,         32'hF8A0_0010}    // R8
  };

  logic            clk = 1'b0;
  logic            rst_n;
  logic            bus_sel, bus_we;
  logic [7:0]      bus_addr;
  logic [3:0]      bus_be;
  logic [31:0]     bus_wdata;
  logic [31:0]     bus_rdata;
  logic            bus_rvalid;
  logic [NIRQ-1:0] irq_pending_o, irq_enable_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqd_bank dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_sel       (bus_sel),
    .bus_we        (bus_we),
    .bus_addr      (bus_addr),
    .bus_be        (bus_be),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .bus_rvalid    (bus_rvalid),
    .irq_pending_o (irq_pending_o),
    .irq_enable_o  (irq_enable_o)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [7:0] a, input logic [3:0] be,
                        input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = we; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_we = 1'b0;
    bus_addr = '0; bus_be = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rdata", 128'(bus_rdata), 128'h0);
    check("R1 rvalid", 128'(bus_rvalid), 128'h0);
    check("R1 pending", 128'(irq_pending_o), 128'h0);
    check("R1 enable", 128'(irq_enable_o), 128'h0);
    rst_n = 1'b1;
    access(1'b0, 8'h48, 4'hF, 32'h0);
    check("R1 prio reset", 128'(bus_rdata), 128'h0);
    check("R10 rvalid after read", 128'(bus_rvalid), 128'h1);

    for (int k = 0; k < NVEC; k++) begin
      access(VEC[k][76], VEC[k][75:68], VEC[k][67:64], VEC[k][63:32]);
      if (VEC[k][76]) begin
        check($sformatf("R10 no rvalid after write vec%0d", k), 128'(bus_rvalid), 128'h0);
      end else begin
        check($sformatf("R2-R9 read vec%0d", k), 128'(bus_rdata), 128'(VEC[k][31:0]));
      end
    end

    // R11 line vectors reflect state
    check("R11 enable vector", 128'(irq_enable_o[47:0]), 128'h00FF_0000_00E0);
    check("R11 pending vector", 128'(irq_pending_o[47:0]), 128'h0005_FFFF_0000);
    check("R11 upper lines idle", 128'(irq_enable_o[95:48]), 128'h0);

    // R10 back-to-back idle keeps rvalid low
    @(negedge clk);
    check("R10 idle", 128'(bus_rvalid), 128'h0);

    // R1 reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 enable after reset", 128'(irq_enable_o), 128'h0);
    check("R1 pending after reset", 128'(irq_pending_o), 128'h0);
    rst_n = 1'b1;
    access(1'b0, 8'h82, 4'hF, 32'h0);
    check("R1 cfg after reset", 128'(bus_rdata), 128'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule